// File: doc/BRIEF.md
# Three-Bridge Gate Command Unit with Shoot-Through Interlock

This block turns per-switch command bits into gate-drive levels for three half-bridges. Each bridge has a high-side and a low-side switch. Every switch has a static enable bit and a select bit that lets it follow one PWM pin shared by all switches. A run bit stops every stage, and fault flags from a protection block force single switches off. The PWM pin comes from outside the clock domain and passes through a two-flop synchroniser before any use.

A per-bridge interlock stops the two switches of a bridge from conducting together. If both are requested, it drives both low and raises a conflict flag. When a bridge hands over from one side to the other, the side coming on waits for a programmable dead time, counted in system clocks, after its partner went low. A switch that follows PWM on its own, with its partner idle, is not held back.

Top module: `bridge_gate_top`

## Requirements
- R1: After reset all six gate outputs and all three conflict flags are low.
- R2: A switch whose enable bit is clear is driven low one clock after the bit is seen, whatever the PWM pin, select bit or partner do.
- R3: A switch with its enable bit set and its select bit clear is held high, provided no fault, no standby and no conflict apply.
- R4: A switch with enable and select both set follows the PWM pin. A pin change made between clock edges reaches the gate output on the third rising edge after it.
- R5: With the run bit low, all six gates go low on the next edge. With it high again, the gates return to what the other inputs command.
- R6: A set fault flag drives only its own switch low on the next edge. The other switches are unaffected.
- R7: If both switches of a bridge are requested at once (after enable, select, PWM, run and fault masking), both gates of that bridge go low and its conflict flag is high in the same cycle. The flag clears once the requests no longer collide.
- R8: On a handover inside a bridge, the switch coming on rises exactly DEAD_CYC+1 clock periods after its partner fell. Both gates are low for that whole interval.
- R9: The high-side and low-side gates of one bridge are never high in the same cycle.

Bit index 2b of every 6-bit vector is the low side of bridge b, and index 2b+1 is the high side. Conflict bit b belongs to bridge b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwmPin | input | 1 | Shared PWM pin, asynchronous |
| runEn | input | 1 | 1 = normal operation, 0 = standby (all gates low) |
| swEnable | input | 6 | Static enable per switch |
| pwmSelect | input | 6 | PWM-follow select per switch |
| faultOff | input | 6 | Fault disable per switch from the protection block |
| gateOut | output | 6 | Gate drive per switch |
| conflict | output | 3 | Per-bridge flag: both sides requested |

## Verification
Each bridge is swept through every combination of the two enable bits and two select bits, with the PWM pin at both levels. A rotation gives the three bridges different combinations, so static-on, PWM-off, PWM-on, disabled and colliding requests show up side by side. One-hot fault flags separate a fault that stays on its own switch from one that spreads to the partner or to another bridge. Timed sequences then count the clocks between a PWM pin change and its gate edge, and the clocks both gates stay low during a handover, so any extra or missing register stage shows up.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // Strobes from the interlock control to the gate datapath for one bridge.
  typedef struct packed {
    logic hiOn;
    logic loOn;
  } gate_grant_t;
endpackage

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int NUM_BRIDGES = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwmPin,
  input  logic                       runEn,
  input  logic [2*NUM_BRIDGES-1:0]   swEnable,
  input  logic [2*NUM_BRIDGES-1:0]   pwmSelect,
  input  logic [2*NUM_BRIDGES-1:0]   faultOff,
  input  gate_grant_t                grant [NUM_BRIDGES],
  output logic [2*NUM_BRIDGES-1:0]   swRequest,
  output logic [2*NUM_BRIDGES-1:0]   gateOut
);
  localparam int NSW = 2 * NUM_BRIDGES;

  logic pwmMeta, pwmSync;
  logic [NSW-1:0] gateQ;

  // Two-flop synchroniser for the external PWM pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwmMeta <= 1'b0;
      pwmSync <= 1'b0;
    end else begin
      pwmMeta <= pwmPin;
      pwmSync <= pwmMeta;
    end
  end

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    // Request: enabled, running, not faulted, and either static or PWM high.
    assign swRequest[i] = runEn & swEnable[i] & ~faultOff[i] & (~pwmSelect[i] | pwmSync);

    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      faultOff[i] |=> !gateOut[i]);  // R6
    AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !swEnable[i] |=> !gateOut[i]);  // R2
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gateQ[2*b]   <= 1'b0;
        gateQ[2*b+1] <= 1'b0;
      end else begin
        gateQ[2*b]   <= grant[b].loOn;
        gateQ[2*b+1] <= grant[b].hiOn;
      end
    end
  end

  assign gateOut = gateQ;

  AST_SYNC_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    pwmSync == $past(pwmMeta));  // R4
  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> (gateOut == '0));  // R5
endmodule

// File: rtl/hbg_interlock.sv
module hbg_interlock
  import hbg_pkg::*;
#(
  parameter int NUM_BRIDGES = 3,
  parameter int DEAD_CYC    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*NUM_BRIDGES-1:0]   swRequest,
  input  logic [2*NUM_BRIDGES-1:0]   gateOut,
  output gate_grant_t                grant [NUM_BRIDGES],
  output logic [NUM_BRIDGES-1:0]     conflict
);
  localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    logic reqLo, reqHi, clash, gLo, gHi;
    logic [CW-1:0] offLo, offHi;   // cycles each side has been low, saturating
    logic clashQ;

    assign reqLo = swRequest[2*b];
    assign reqHi = swRequest[2*b+1];
    assign gLo   = gateOut[2*b];
    assign gHi   = gateOut[2*b+1];
    assign clash = reqLo & reqHi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        offLo  <= DEAD_V;
        offHi  <= DEAD_V;
        clashQ <= 1'b0;
      end else begin
        clashQ <= clash;
        if (gLo) offLo <= '0;
        else if (offLo != DEAD_V) offLo <= offLo + 1'b1;
        if (gHi) offHi <= '0;
        else if (offHi != DEAD_V) offHi <= offHi + 1'b1;
      end
    end

    // A side stays on while requested; it may come on only once the partner
    // is low and has been low for the full dead time.
    always_comb begin
      grant[b].hiOn = reqHi & ~clash & (gHi | (~gLo & (offLo == DEAD_V)));
      grant[b].loOn = reqLo & ~clash & (gLo | (~gHi & (offHi == DEAD_V)));
    end

    assign conflict[b] = clashQ;

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      !(gHi && gLo));  // R9
    AST_CONFLICT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      clashQ |-> (!gHi && !gLo));  // R7
    AST_DEAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gHi) |-> $past(offLo == DEAD_V && !gLo));  // R8
    AST_DEAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gLo) |-> $past(offHi == DEAD_V && !gHi));  // R8
  end
endmodule

// File: rtl/bridge_gate_top.sv
module bridge_gate_top
  import hbg_pkg::*;
#(
  parameter int NUM_BRIDGES = 3,
  parameter int DEAD_CYC    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwmPin,
  input  logic                       runEn,
  input  logic [2*NUM_BRIDGES-1:0]   swEnable,
  input  logic [2*NUM_BRIDGES-1:0]   pwmSelect,
  input  logic [2*NUM_BRIDGES-1:0]   faultOff,
  output logic [2*NUM_BRIDGES-1:0]   gateOut,
  output logic [NUM_BRIDGES-1:0]     conflict
);
  gate_grant_t grant [NUM_BRIDGES];
  logic [2*NUM_BRIDGES-1:0] swRequest;

  hbg_datapath #(.NUM_BRIDGES(NUM_BRIDGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .pwmPin(pwmPin), .runEn(runEn),
    .swEnable(swEnable), .pwmSelect(pwmSelect), .faultOff(faultOff),
    .grant(grant), .swRequest(swRequest), .gateOut(gateOut)
  );

  hbg_interlock #(.NUM_BRIDGES(NUM_BRIDGES), .DEAD_CYC(DEAD_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .swRequest(swRequest), .gateOut(gateOut),
    .grant(grant), .conflict(conflict)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    $rose(rst_n) |-> (gateOut == '0 && conflict == '0));  // R1
endmodule

// File: tb/bridge_gate_top_tb_top.sv
module bridge_gate_top_tb_top;
  localparam int DEAD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwmPin = 1'b0;
  logic runEn = 1'b0;
  logic [5:0] swEnable = '0, pwmSelect = '0, faultOff = '0;
  logic [5:0] gateOut;
  logic [2:0] conflict;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bridge_gate_top #(.NUM_BRIDGES(3), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwmPin(pwmPin), .runEn(runEn),
    .swEnable(swEnable), .pwmSelect(pwmSelect), .faultOff(faultOff),
    .gateOut(gateOut), .conflict(conflict)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] reqOf(input logic [5:0] en, input logic [5:0] sel,
                                       input logic [5:0] flt, input logic pin, input logic run);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = run & en[i] & ~flt[i] & (~sel[i] | pin);
    return r;
  endfunction

  function automatic logic [5:0] expGate(input logic [5:0] r);
    logic [5:0] g = r;
    for (int b = 0; b < 3; b++) if (r[2*b] & r[2*b+1]) begin g[2*b] = 0; g[2*b+1] = 0; end
    return g;
  endfunction

  function automatic logic [2:0] expClash(input logic [5:0] r);
    logic [2:0] c;
    for (int b = 0; b < 3; b++) c[b] = r[2*b] & r[2*b+1];
    return c;
  endfunction

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] r;
    int cnt;
    waitCyc(3);
    check("R1 gates after reset", gateOut, 6'b0);
    check("R1 conflict after reset", {3'b0, conflict}, 6'b0);
    @(negedge clk); rst_n = 1'b1; runEn = 1'b1;
    waitCyc(2);
    check("R1 gates idle", gateOut, 6'b0);

    // Sweep: per bridge {enLo, selLo, enHi, selHi} across both pin levels.
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 2; p++) begin
        for (int b = 0; b < 3; b++) begin
          int cc = (c + 5 * b) % 16;
          swEnable[2*b]    = cc[3];
          pwmSelect[2*b]   = cc[2];
          swEnable[2*b+1]  = cc[1];
          pwmSelect[2*b+1] = cc[0];
        end
        pwmPin = p[0];
        waitCyc(DEAD + 8);
        r = reqOf(swEnable, pwmSelect, faultOff, pwmPin, runEn);
        check("R2 R3 R4 R7 sweep gates", gateOut, expGate(r));
        check("R7 sweep conflict", {3'b0, conflict}, {3'b0, expClash(r)});
      end
    end

    // Faults: all high sides static on, lo sides off; one-hot fault.
    swEnable = 6'b101010; pwmSelect = '0; pwmPin = 0;
    waitCyc(DEAD + 8);
    for (int f = 0; f < 6; f++) begin
      faultOff = 6'(1) << f;
      waitCyc(2);
      check("R6 fault one switch", gateOut, 6'b101010 & ~faultOff);
      faultOff = '0;
      waitCyc(DEAD + 8);
    end
    faultOff = 6'b000010;
    @(negedge clk);
    check("R6 fault next edge", gateOut, 6'b101000);
    faultOff = '0;
    waitCyc(DEAD + 8);

    // Standby
    runEn = 0;
    @(negedge clk);
    check("R5 standby off", gateOut, 6'b0);
    waitCyc(3);
    check("R5 standby held", gateOut, 6'b0);
    runEn = 1;
    waitCyc(DEAD + 8);
    check("R5 resume", gateOut, 6'b101010);

    // Handover on bridge 0: high side to low side.
    swEnable = 6'b000010; waitCyc(DEAD + 8);
    check("R3 bridge0 high on", gateOut, 6'b000010);
    swEnable = 6'b000001;
    cnt = 0;
    @(negedge clk);
    check("R2 high drops next edge", gateOut, 6'b000000);
    while (gateOut == 6'b0 && cnt < 100) begin cnt++; @(negedge clk); end
    check("R8 dead gap hi->lo", 6'(cnt), 6'(DEAD + 1));
    check("R9 lo only after gap", gateOut, 6'b000001);
    swEnable = 6'b000010;
    cnt = 0;
    @(negedge clk);
    while (gateOut == 6'b0 && cnt < 100) begin cnt++; @(negedge clk); end
    check("R8 dead gap lo->hi", 6'(cnt), 6'(DEAD + 1));

    // PWM latency on bridge 1 high side, partner idle.
    swEnable = 6'b001000; pwmSelect = 6'b001000; pwmPin = 0;
    waitCyc(DEAD + 8);
    check("R4 pwm low", gateOut, 6'b0);
    pwmPin = 1;
    waitCyc(2);
    check("R4 two edges after rise", gateOut, 6'b0);
    @(negedge clk);
    check("R4 three edges after rise", gateOut, 6'b001000);
    pwmPin = 0;
    waitCyc(2);
    check("R4 two edges after fall", gateOut, 6'b001000);
    @(negedge clk);
    check("R4 three edges after fall", gateOut, 6'b0);
    pwmPin = 1;
    waitCyc(3);
    check("R4 same side re-on without dead time", gateOut, 6'b001000);
    swEnable = 6'b000000;
    @(negedge clk);
    check("R2 disable overrides pwm", gateOut, 6'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule